// File: doc/BRIEF.md
# Masked GPIO Set/Clear Output Port

This block controls a 32-pin general-purpose output port behind a small memory-mapped register bus. It holds a direction register, a mask register and an output latch. Software changes the latch through two write-only action registers: one raises pins and one lowers them, and each acts only on the bits written as 1. An action reaches a pin only when three conditions hold together. The pin must be an output, the per-pin function select must leave it in GPIO mode, and its mask bit must allow access.

Each of the four byte strobes carries its own byte of write data to its own group of eight pins. A full-word, half-word or single-byte write therefore touches exactly the pins it covers. Software never needs a read-modify-write. Reads are combinational. A write completes in the cycle it is presented and shows at the pins after the next rising clock edge.

Top module: `gpio_mask_port`

## Requirements
- R1: While rst_ni is low, pin_o, dir_o, the direction register, the mask register and the output latch are all zero.
- R2: A write to the set register (byte offset 0x8) drives high every enabled pin whose written bit is 1.
- R3: A write to the clear register (byte offset 0xC) drives low every enabled pin whose written bit is 1.
- R4: A bit written as 0 to the set or clear register leaves its pin unchanged.
- R5: A pin whose direction bit is 0 (input) is not changed by set or clear writes. Direction register byte offset 0x0, bit n = pin n, 1 = output.
- R6: A pin whose fsel_i bit is 1 (alternate function) is not changed by set or clear writes. fsel_i is taken from the cycle of the write itself.
- R7: A pin whose mask bit is 1 is not changed by set or clear writes. Mask register byte offset 0x4, bit n = pin n, 0 = access allowed.
- R8: Byte strobe be_i[k] carries wdata_i[8k+7:8k] to pins 8k..8k+7. Pins in lanes whose strobe is 0 are unchanged. This holds for full-word, upper or lower half-word and single-byte writes.
- R9: Direction and mask writes update only the byte lanes whose strobe is 1.
- R10: With we_i low, rdata_o returns the direction register at 0x0, the mask at 0x4, the output latch at 0x8 and zero at 0xC, in the same cycle.
- R11: An enabled set or clear write shows on pin_o after the first rising clock edge with we_i high, with no further delay.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| addr_i | input | 4 | Byte address (bits 3:2 pick the register) |
| we_i | input | 1 | Write enable |
| be_i | input | 4 | Byte-lane strobes |
| wdata_i | input | 32 | Write data |
| rdata_o | output | 32 | Read data |
| fsel_i | input | 32 | Per-pin function select, 1 = alternate function |
| pin_o | output | 32 | Output latch value |
| dir_o | output | 32 | Direction register, 1 = output |

## Verification
Two things can land in the same cycle as a set or clear write: a change of the function select input and the gating from earlier direction and mask writes. The bench flips fsel_i in the very cycle of a write to some pins and flips it back on the next. It then expects the pins selected during the write to keep their old level, while the other pins in the same byte move. Partial-lane writes carry non-zero data in the unstrobed bytes, so a lane leak shows up as a wrong pin value.

// File: rtl/gpio_port_pkg.sv
package gpio_port_pkg;
  typedef enum logic [1:0] {
    REG_DIR  = 2'd0,
    REG_MASK = 2'd1,
    REG_SET  = 2'd2,
    REG_CLR  = 2'd3
  } reg_sel_e;
endpackage

// File: rtl/gpio_lane_expand.sv
module gpio_lane_expand #(
  parameter int DATA_W = 32,
  parameter int LANE_W = 8,
  localparam int NLANES = DATA_W / LANE_W
) (
  input  logic [NLANES-1:0] be_i,
  output logic [DATA_W-1:0] lane_mask_o
);
  for (genvar k = 0; k < NLANES; k++) begin : g_lane
    assign lane_mask_o[k*LANE_W +: LANE_W] = {LANE_W{be_i[k]}};
  end
endmodule

// File: rtl/gpio_cfg_regs.sv
module gpio_cfg_regs #(
  parameter int DATA_W = 32
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              dir_we_i,
  input  logic              mask_we_i,
  input  logic [DATA_W-1:0] lane_mask_i,
  input  logic [DATA_W-1:0] wdata_i,
  output logic [DATA_W-1:0] dir_o,
  output logic [DATA_W-1:0] mask_o
);
  logic [DATA_W-1:0] dir_q, mask_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      dir_q  <= '0;
      mask_q <= '0;
    end else begin
      if (dir_we_i)  dir_q  <= (dir_q  & ~lane_mask_i) | (wdata_i & lane_mask_i);
      if (mask_we_i) mask_q <= (mask_q & ~lane_mask_i) | (wdata_i & lane_mask_i);
    end
  end

  assign dir_o  = dir_q;
  assign mask_o = mask_q;

  // R9
  cfg_lane_keep_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (dir_we_i || mask_we_i) |=>
      (((dir_q ^ $past(dir_q)) | (mask_q ^ $past(mask_q))) & ~$past(lane_mask_i)) == '0);
endmodule

// File: rtl/gpio_out_latch.sv
module gpio_out_latch #(
  parameter int DATA_W = 32
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [DATA_W-1:0] set_i,
  input  logic [DATA_W-1:0] clr_i,
  input  logic [DATA_W-1:0] en_i,
  output logic [DATA_W-1:0] out_o
);
  logic [DATA_W-1:0] out_q, set_eff, clr_eff;

  assign set_eff = set_i & en_i;
  assign clr_eff = clr_i & en_i;

  // clear takes priority over set on the same pin
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) out_q <= '0;
    else         out_q <= (out_q | set_eff) & ~clr_eff;
  end

  assign out_o = out_q;

  // R2
  set_high_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (|(set_i & en_i & ~clr_i)) |=> ((~out_q & $past(set_i & en_i & ~clr_i)) == '0));
  // R3
  clr_low_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (|(clr_i & en_i)) |=> ((out_q & $past(clr_i & en_i)) == '0));
  // R4, R5, R6, R7
  blocked_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    1'b1 |=> (((out_q ^ $past(out_q)) & ~$past((set_i | clr_i) & en_i)) == '0));
endmodule

// File: rtl/gpio_mask_port.sv
module gpio_mask_port
  import gpio_port_pkg::*;
#(
  parameter int DATA_W = 32,
  parameter int LANE_W = 8,
  parameter int ADDR_W = 4,
  localparam int NLANES = DATA_W / LANE_W
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic              we_i,
  input  logic [NLANES-1:0] be_i,
  input  logic [DATA_W-1:0] wdata_i,
  output logic [DATA_W-1:0] rdata_o,
  input  logic [DATA_W-1:0] fsel_i,
  output logic [DATA_W-1:0] pin_o,
  output logic [DATA_W-1:0] dir_o
);
  reg_sel_e          sel;
  logic [DATA_W-1:0] lane_mask, wdata_lanes, dir_q, mask_q, en, set_v, clr_v;

  assign sel = reg_sel_e'(addr_i[3:2]);

  gpio_lane_expand #(.DATA_W(DATA_W), .LANE_W(LANE_W)) u_lanes (
    .be_i        (be_i),
    .lane_mask_o (lane_mask)
  );

  gpio_cfg_regs #(.DATA_W(DATA_W)) u_cfg (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .dir_we_i    (we_i && sel == REG_DIR),
    .mask_we_i   (we_i && sel == REG_MASK),
    .lane_mask_i (lane_mask),
    .wdata_i     (wdata_i),
    .dir_o       (dir_q),
    .mask_o      (mask_q)
  );

  assign wdata_lanes = wdata_i & lane_mask;
  assign en    = dir_q & ~mask_q & ~fsel_i;
  assign set_v = (we_i && sel == REG_SET) ? wdata_lanes : '0;
  assign clr_v = (we_i && sel == REG_CLR) ? wdata_lanes : '0;

  gpio_out_latch #(.DATA_W(DATA_W)) u_latch (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .set_i  (set_v),
    .clr_i  (clr_v),
    .en_i   (en),
    .out_o  (pin_o)
  );

  always_comb begin
    unique case (sel)
      REG_DIR:  rdata_o = dir_q;
      REG_MASK: rdata_o = mask_q;
      REG_SET:  rdata_o = pin_o;
      default:  rdata_o = '0;
    endcase
  end

  assign dir_o = dir_q;

  // R1
  rst_zero_chk: assert property (@(posedge clk_i)
    !rst_ni |-> (pin_o == '0 && dir_o == '0));
  // R10
  clr_read_zero_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (addr_i[3:2] == 2'd3) |-> (rdata_o == '0));
  // R11
  write_settle_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !we_i |=> $stable(pin_o));
endmodule

// File: tb/sim_gpio_mask_port.sv
`timescale 1ns/1ps
module sim_gpio_mask_port;
  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic [3:0]  addr_i = '0;
  logic        we_i = 1'b0;
  logic [3:0]  be_i = '0;
  logic [31:0] wdata_i = '0;
  logic [31:0] fsel_i = '0;
  logic [31:0] rdata_o, pin_o, dir_o;

  int errors = 0;
  int checks = 0;
  logic [31:0] m_out = '0, m_dir = '0, m_mask = '0;

  logic [31:0] exp_q[$];
  bit          kind_q[$];
  string       tag_q[$];

  always #4 clk_i = ~clk_i;

  gpio_mask_port u0 (
    .clk_i(clk_i), .rst_ni(rst_ni), .addr_i(addr_i), .we_i(we_i), .be_i(be_i),
    .wdata_i(wdata_i), .rdata_o(rdata_o), .fsel_i(fsel_i), .pin_o(pin_o), .dir_o(dir_o)
  );

  task automatic push(input logic [31:0] exp, input bit is_rd, input string tag);
    exp_q.push_back(exp);
    kind_q.push_back(is_rd);
    tag_q.push_back(tag);
  endtask

  // monitor: compares queued expectations away from the rising edge
  always @(negedge clk_i) begin
    while (exp_q.size() > 0) begin
      logic [31:0] e, a;
      bit    k;
      string t;
      e = exp_q.pop_front();
      k = kind_q.pop_front();
      t = tag_q.pop_front();
      a = k ? rdata_o : pin_o;
      checks++;
      if (a !== e) begin
        errors++;
        $display("FAIL %s: actual=%h expected=%h", t, a, e);
      end
    end
  end

  function automatic logic [31:0] lanes(input logic [3:0] be);
    logic [31:0] m;
    for (int k = 0; k < 4; k++) m[k*8 +: 8] = {8{be[k]}};
    return m;
  endfunction

  task automatic wr(input logic [3:0] a, input logic [3:0] be, input logic [31:0] d,
                    input logic [31:0] fs, input string tag);
    logic [31:0] lm, en;
    @(negedge clk_i); #1;
    addr_i = a; be_i = be; wdata_i = d; fsel_i = fs; we_i = 1'b1;
    lm = lanes(be);
    en = m_dir & ~m_mask & ~fs;
    case (a[3:2])
      2'd0: m_dir  = (m_dir  & ~lm) | (d & lm);
      2'd1: m_mask = (m_mask & ~lm) | (d & lm);
      2'd2: m_out  = m_out | (d & lm & en);
      default: m_out = m_out & ~(d & lm & en);
    endcase
    @(posedge clk_i); #1;
    we_i = 1'b0;
    push(m_out, 1'b0, tag);
  endtask

  task automatic rd(input logic [3:0] a, input logic [31:0] exp, input string tag);
    @(negedge clk_i); #1;
    addr_i = a; we_i = 1'b0;
    push(exp, 1'b1, tag);
    @(posedge clk_i);
  endtask

  initial begin
    #400000;
    errors++;
    $display("FAIL watchdog: actual=running expected=done");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    // R1 reset state
    repeat (3) @(posedge clk_i);
    #1;
    push(32'h0, 1'b0, "R1 pin_o in reset");
    @(negedge clk_i);
    checks++;
    if (dir_o !== 32'h0) begin errors++; $display("FAIL R1: actual=%h expected=0", dir_o); end
    rst_ni = 1'b1;
    rd(4'h8, 32'h0, "R1 latch after reset");
    rd(4'h4, 32'h0, "R1 mask after reset");

    // R9 direction write per lane, R10 readback
    wr(4'h0, 4'b0011, 32'hFFFF_FFFF, '0, "R9 dir low half");
    rd(4'h0, 32'h0000_FFFF, "R9 R10 dir readback");
    wr(4'h0, 4'b1100, 32'hFFFF_1234, '0, "R9 dir upper half");
    rd(4'h0, 32'hFFFF_FFFF, "R9 dir full");

    // R2 R11 set, R4 zero bits
    wr(4'h8, 4'b1111, 32'h0000_00F0, '0, "R2 R11 set word");
    wr(4'h8, 4'b1111, 32'h0, '0, "R4 set zero");
    // R3 clear
    wr(4'hC, 4'b1111, 32'h0000_0030, '0, "R3 clear word");
    wr(4'hC, 4'b1111, 32'h0, '0, "R4 clear zero");

    // R8 lanes
    wr(4'h8, 4'b1000, 32'hA5FF_FFFF, '0, "R8 byte lane 3");
    wr(4'h8, 4'b1100, 32'h5A5A_FFFF, '0, "R8 upper half");
    wr(4'hC, 4'b0011, 32'hFFFF_00C0, '0, "R8 lower half clear");
    wr(4'h8, 4'b0100, 32'hFF3C_FFFF, '0, "R8 byte lane 2");
    rd(4'h8, m_out, "R10 latch read");
    rd(4'hC, 32'h0, "R10 clear reads zero");

    // R5 input pins
    wr(4'h0, 4'b0001, 32'hFFFF_FF00, '0, "R5 lane0 inputs");
    wr(4'h8, 4'b0001, 32'h0000_00FF, '0, "R5 set on inputs");
    wr(4'h0, 4'b0001, 32'h0000_00FF, '0, "R5 lane0 outputs");
    wr(4'h8, 4'b0001, 32'h0000_000F, '0, "R5 set after restore");

    // R6 function select sampled in the write cycle
    wr(4'h8, 4'b0001, 32'h0000_00F0, 32'h0000_0030, "R6 alt pins held");
    wr(4'hC, 4'b0001, 32'h0000_00FF, 32'h0000_0005, "R6 alt pins clear held");

    // R7 mask
    wr(4'h4, 4'b0010, 32'h0000_0F00, '0, "R7 mask write");
    rd(4'h4, 32'h0000_0F00, "R7 R10 mask readback");
    wr(4'h8, 4'b0010, 32'h0000_FF00, '0, "R7 masked set");
    wr(4'hC, 4'b1111, 32'hFFFF_FFFF, '0, "R7 masked clear");
    wr(4'h4, 4'b1111, 32'h0, '0, "R7 unmask");
    wr(4'hC, 4'b1111, 32'hFFFF_FFFF, '0, "R3 clear all");

    repeat (3) @(negedge clk_i);
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule